// File: doc/BRIEF.md
# Configurable SPI Master/Slave Port

This block is a serial peripheral port that moves 8-bit characters, most significant bit first, as either the clock-driving master or a clocked slave. Software programs it through a small register bus with four addresses: control, status, data and an auxiliary options register. In master mode the block generates SCK at one of four rates. It shifts a byte out on MOSI and, on the same clock edges, captures a byte from MISO. In slave mode it follows an external SCK, which passes through a two-stage synchronizer together with the select and data inputs.

Clock polarity and phase select any of the four transfer formats. Any of the three pin outputs can be released through its output-enable signal. In slave mode the select input may be ignored, so that the pin is free for other uses. A slave can also keep its MISO driver off, which lets several slaves share one select line and be addressed through the first byte on the bus. In master mode the block watches the select input for another master pulling it low; when that happens it drops out of master mode. One interrupt line combines three sources: transfer completion, mode fault, and a separately gated transmit-buffer-empty event.

Top module: `spi_port`

## Requirements
- R1: A master transfer sends the byte written to DATA (address 2) on MOSI MSB first over 8 SCK cycles. It then sets the done flag (STATUS bit 7, address 1), and reading DATA returns the byte captured from MISO.
- R2: CTRL (address 0) has the fields rate [1:0], cpha [2], cpol [3], master [4], enable [5] and irq_en [6]. When idle, SCK sits at the cpol level. With cpha=0 data is sampled on the leading edge (the edge leaving the idle level); with cpha=1 it is sampled on the trailing edge.
- R3: In master mode, SCK edges are spaced 2, 8, 32 or 64 system clocks apart for rate 0, 1, 2 or 3, which gives a bit period of clk/4, clk/16, clk/64 or clk/128.
- R4: A CTRL write while enable is already 1 leaves cpol, cpha and rate unchanged.
- R5: In master mode with ss_ignore=0, a low level on ss_n_i is a mode fault. The fault clears master, sets STATUS bit 6, drops sck_oe and mosi_oe, and raises irq_o when irq_en=1. Any CTRL write clears the fault flag.
- R6: With ss_ignore (AUX bit 0, address 3) set to 1, a low ss_n_i never causes a mode fault.
- R7: A slave with ss_ignore=0 transfers only while ss_n_i is low. While ss_n_i is high it ignores SCK, does not set done and keeps miso_oe low.
- R8: A slave with ss_ignore=1 transfers whenever enable is set, whatever the level of ss_n_i.
- R9: With miso_off (AUX bit 1) set to 1, miso_oe stays low even when the slave is selected.
- R10: irq_o = irq_en AND (done OR fault OR (txe_irq_en AND tx_empty)). Here txe_irq_en is AUX bit 2 and tx_empty is STATUS bit 5, which reads 1 when the transmit buffer is empty.
- R11: The done flag clears only when STATUS is read while done is set and DATA is accessed afterwards. Accessing DATA without that status read leaves done set.
- R12: A slave with cpha=0 presents the MSB of its loaded byte on miso_o once it is selected, before the first SCK edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address: 0 CTRL, 1 STATUS, 2 DATA, 3 AUX |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (drives read side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| sck_i | input | 1 | Serial clock input (slave) |
| sck_o | output | 1 | Serial clock output (master) |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Serial data input (slave) |
| mosi_o | output | 1 | Serial data output (master) |
| mosi_oe | output | 1 | Master data output enable |
| miso_i | input | 1 | Serial data input (master) |
| miso_o | output | 1 | Serial data output (slave) |
| miso_oe | output | 1 | Slave data output enable |
| ss_n_i | input | 1 | Active-low select input |
| irq_o | output | 1 | Combined interrupt |

## Verification
If the edge counter or the sample/shift choice goes wrong, the byte seen on MOSI or read back from DATA is rotated or has a repeated bit, and this shows within one character time. A wrong divider count changes the measured gap between SCK edges from the first edge onward. Faults in the flag state appear on irq_o and the status bits one or two clocks after the event that caused them, and a synchronizer stage too many or too few shifts slave responses only by clocks that stay inside a half bit.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    localparam int BYTE_W  = 8;
    localparam int RATE_W  = 2;
    localparam int CNT_W   = 7;
    localparam int EDGE_W  = $clog2(2 * BYTE_W);
    localparam int ADDR_W  = 2;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] A_DATA = 2'd2;
    localparam logic [ADDR_W-1:0] A_AUX  = 2'd3;

    localparam logic [EDGE_W-1:0] EDGE_LAST = EDGE_W'(2 * BYTE_W - 1);

    // system clocks between SCK edges for each rate code
    function automatic logic [CNT_W-1:0] half_period(input logic [RATE_W-1:0] rate);
        case (rate)
            2'd0:    half_period = CNT_W'(2);
            2'd1:    half_period = CNT_W'(8);
            2'd2:    half_period = CNT_W'(32);
            default: half_period = CNT_W'(64);
        endcase
    endfunction

    typedef struct packed {
        logic              en;
        logic              mstr;
        logic              irq_en;
        logic              cpol;
        logic              cpha;
        logic [RATE_W-1:0] rate;
        logic              ss_ign;
        logic              miso_off;
        logic              txe_ie;
        logic [BYTE_W-1:0] tx_buf;
        logic              tx_full;
        logic [BYTE_W-1:0] sh;
        logic [BYTE_W-1:0] rx_sh;
        logic [BYTE_W-1:0] rx_data;
        logic              done;
        logic              modf;
        logic              arm;
        logic              busy;
        logic [EDGE_W-1:0] edge_cnt;
        logic              phase;
        logic              sck_prev;
    } port_state_t;

endpackage

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/spi_port_rate_div.sv
module spi_port_rate_div #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [CNT_W-1:0] half_i,
    output logic             tick_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q == half_i - 1'b1);
        cnt_d  = (!run_i || tick_o) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3: smallest spacing is two clocks, so ticks never come back to back
    a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/spi_port.sv
module spi_port
    import spi_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              mosi_i,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              miso_i,
    output logic              miso_o,
    output logic              miso_oe,
    input  logic              ss_n_i,
    output logic              irq_o
);

    port_state_t s_d, s_q;

    logic [2:0] pins_s;
    logic       ss_s, sck_s, mosi_s;
    logic       tick;

    logic              master_run, slave_act, slv_edge, edge_ev;
    logic              din, smp, shf, last, data_acc, fault;
    logic [BYTE_W-1:0] rx_next;

    spi_port_sync #(.WIDTH(3), .STAGES(2), .RST_VAL(3'b100)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ss_n_i, sck_i, mosi_i}),
        .sync_o  (pins_s)
    );
    assign {ss_s, sck_s, mosi_s} = pins_s;

    spi_port_rate_div #(.CNT_W(CNT_W)) div_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (s_q.en && s_q.mstr && s_q.busy),
        .half_i (half_period(s_q.rate)),
        .tick_o (tick)
    );

    always_comb begin
        s_d = s_q;

        master_run = s_q.en && s_q.mstr;
        slave_act  = s_q.en && !s_q.mstr && (s_q.ss_ign || !ss_s);
        slv_edge   = slave_act && (sck_s != s_q.sck_prev);
        edge_ev    = master_run ? (s_q.busy && tick) : slv_edge;
        din        = master_run ? miso_i : mosi_s;
        smp        = (s_q.edge_cnt[0] == s_q.cpha);
        shf        = !smp && (s_q.edge_cnt != '0);
        last       = (s_q.edge_cnt == EDGE_LAST);
        rx_next    = smp ? {s_q.rx_sh[BYTE_W-2:0], din} : s_q.rx_sh;
        fault      = master_run && !s_q.ss_ign && !ss_s;
        data_acc   = (bus_rd || bus_wr) && (bus_addr == A_DATA);

        s_d.sck_prev = sck_s;

        // shift engine shared by both modes
        if (!master_run && !slave_act) begin
            s_d.busy     = 1'b0;
            s_d.edge_cnt = '0;
            s_d.phase    = 1'b0;
        end else if (edge_ev) begin
            s_d.rx_sh    = rx_next;
            if (shf) s_d.sh = {s_q.sh[BYTE_W-2:0], 1'b0};
            s_d.edge_cnt = s_q.edge_cnt + 1'b1;
            if (master_run) s_d.phase = !s_q.phase;
            if (last) begin
                s_d.done    = 1'b1;
                s_d.rx_data = rx_next;
                s_d.busy    = 1'b0;
            end
        end else if (s_q.edge_cnt == '0 && !s_q.busy && s_q.tx_full) begin
            s_d.sh      = s_q.tx_buf;
            s_d.tx_full = 1'b0;
            s_d.busy    = master_run;
            s_d.phase   = 1'b0;
        end

        // collision on the select line while driving the bus
        if (fault) begin
            s_d.mstr     = 1'b0;
            s_d.modf     = 1'b1;
            s_d.busy     = 1'b0;
            s_d.edge_cnt = '0;
            s_d.phase    = 1'b0;
        end

        // register bus
        if (bus_wr) begin
            case (bus_addr)
                A_CTRL: begin
                    s_d.irq_en = bus_wdata[6];
                    s_d.en     = bus_wdata[5];
                    s_d.mstr   = bus_wdata[4];
                    s_d.modf   = 1'b0;
                    if (!s_q.en) begin
                        s_d.cpol = bus_wdata[3];
                        s_d.cpha = bus_wdata[2];
                        s_d.rate = bus_wdata[1:0];
                    end
                end
                A_DATA: begin
                    s_d.tx_buf  = bus_wdata;
                    s_d.tx_full = 1'b1;
                end
                A_AUX: begin
                    s_d.txe_ie   = bus_wdata[2];
                    s_d.miso_off = bus_wdata[1];
                    s_d.ss_ign   = bus_wdata[0];
                end
                default: ;
            endcase
        end
        if (bus_rd && bus_addr == A_STAT && s_q.done) s_d.arm = 1'b1;
        if (data_acc && s_q.arm) begin
            s_d.done = 1'b0;
            s_d.arm  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = {1'b0, s_q.irq_en, s_q.en, s_q.mstr, s_q.cpol, s_q.cpha, s_q.rate};
            A_STAT:  bus_rdata = {s_q.done, s_q.modf, !s_q.tx_full, 5'b0};
            A_DATA:  bus_rdata = s_q.rx_data;
            default: bus_rdata = {5'b0, s_q.txe_ie, s_q.miso_off, s_q.ss_ign};
        endcase
    end

    assign sck_o   = s_q.mstr ? (s_q.cpol ^ s_q.phase) : s_q.cpol;
    assign sck_oe  = s_q.en && s_q.mstr;
    assign mosi_o  = s_q.sh[BYTE_W-1];
    assign mosi_oe = s_q.en && s_q.mstr;
    assign miso_o  = s_q.sh[BYTE_W-1];
    assign miso_oe = s_q.en && !s_q.mstr && (s_q.ss_ign || !ss_s) && !s_q.miso_off;
    assign irq_o   = s_q.irq_en && (s_q.done || s_q.modf || (s_q.txe_ie && !s_q.tx_full));

    // R1: completion only after the last of the sixteen edges
    a_r1_done_on_last_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.done) |-> $past(s_q.edge_cnt) == EDGE_LAST);

    // R3: the master clock only moves on a divider tick
    a_r3_sck_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !tick) |=> (!s_q.busy || $stable(s_q.phase)));

    // R4: format and rate hold while enabled
    a_r4_static_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.en && $past(s_q.en)) |-> $stable({s_q.cpol, s_q.cpha, s_q.rate}));

    // R5: a fault releases the master drivers
    a_r5_fault_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.modf) |-> (!sck_oe && !mosi_oe));

    // R10: with the empty-buffer source gated and no other flag, no interrupt
    a_r10_txe_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.txe_ie && !s_q.done && !s_q.modf) |-> !irq_o);

endmodule

// File: tb/spi_port_tb_top.sv
module spi_port_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic       sck_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1;
    logic       sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, irq_o;
    logic       miso_i;

    int checks = 0;
    int errors = 0;
    bit ended  = 1'b0;

    always #2 clk = !clk;

    assign miso_i = mosi_o; // loopback for master transfers

    spi_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck_i(sck_i), .sck_o(sck_o),
        .sck_oe(sck_oe), .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe), .ss_n_i(ss_n_i), .irq_o(irq_o)
    );

    // observer of the master clock: captures MOSI on sample edges, measures spacing
    logic       cur_cpol = 1'b0, cur_cpha = 1'b0, cap_clr = 1'b0;
    logic       prev_sck = 1'b0;
    logic [7:0] cap = '0;
    int         nsamp = 0, since = 0, half_meas = 0;

    always @(negedge clk) begin
        if (cap_clr) begin
            cap   <= '0;
            nsamp <= 0;
        end else if (sck_oe && sck_o != prev_sck) begin
            if ((prev_sck == cur_cpol) != cur_cpha) begin
                cap   <= {cap[6:0], mosi_o};
                nsamp <= nsamp + 1;
            end
            half_meas <= since;
            since     <= 1;
        end else begin
            since <= since + 1;
        end
        prev_sck <= sck_o;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    function automatic logic [7:0] ctl(input bit ie, input bit en, input bit m,
                                       input bit pol, input bit pha, input logic [1:0] r);
        return {1'b0, ie, en, m, pol, pha, r};
    endfunction

    function automatic int exp_half(input logic [1:0] r);
        case (r)
            2'd0: return 2;
            2'd1: return 8;
            2'd2: return 32;
            default: return 64;
        endcase
    endfunction

    task automatic wait_done();
        logic [7:0] st = '0;
        for (int k = 0; k < 3000 && !st[7]; k++) bus_read(2'd1, st);
    endtask

    task automatic slave_xfer(input logic [7:0] b, output logic [7:0] got);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk) mosi_i = b[i];
            repeat (8) @(negedge clk);
            got[i] = miso_o;
            sck_i = 1'b1;
            repeat (8) @(negedge clk);
            sck_i = 1'b0;
        end
        repeat (8) @(negedge clk);
    endtask

    // data, cpol, cpha, rate
    localparam logic [11:0] VEC [4] = '{
        {8'hA5, 1'b0, 1'b0, 2'd0},
        {8'h3C, 1'b0, 1'b1, 2'd1},
        {8'hC3, 1'b1, 1'b0, 2'd2},
        {8'h81, 1'b1, 1'b1, 2'd3}
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd, got;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        bus_read(2'd1, rd);
        chk(rd == 8'h20, "R10 reset status", rd, 8'h20);
        chk(!irq_o && !sck_oe && !miso_oe && !mosi_oe, "R7 reset outputs quiet",
            {irq_o, sck_oe, miso_oe, mosi_oe}, 0);

        // R10 gating of the empty-buffer interrupt
        bus_write(2'd3, 8'h00);
        bus_write(2'd0, ctl(1, 0, 0, 0, 0, 0));
        @(negedge clk);
        chk(!irq_o, "R10 txe gated off", irq_o, 0);
        bus_write(2'd3, 8'h04);
        @(negedge clk);
        chk(irq_o, "R10 txe enabled", irq_o, 1);
        bus_write(2'd0, ctl(0, 0, 0, 0, 0, 0));
        @(negedge clk);
        chk(!irq_o, "R10 global enable off", irq_o, 0);
        bus_write(2'd3, 8'h00);

        // master transfers over the vector table (R1, R2, R3)
        foreach (VEC[v]) begin
            logic [7:0] d;
            d = VEC[v][11:4];
            cur_cpol = VEC[v][3];
            cur_cpha = VEC[v][2];
            bus_write(2'd0, 8'h00);
            bus_write(2'd0, ctl(0, 1, 1, VEC[v][3], VEC[v][2], VEC[v][1:0]));
            repeat (3) @(negedge clk);
            chk(sck_o == cur_cpol, "R2 idle level", sck_o, cur_cpol);
            cap_clr = 1'b1;
            repeat (2) @(negedge clk);
            cap_clr = 1'b0;
            bus_write(2'd2, d);
            wait_done();
            bus_read(2'd2, rd);
            chk(rd == d, "R1 loopback byte", rd, d);
            chk(cap == d && nsamp == 8, "R1 R2 MSB first on sample edges", cap, d);
            chk(half_meas == exp_half(VEC[v][1:0]), "R3 edge spacing", half_meas,
                exp_half(VEC[v][1:0]));
            chk(sck_o == cur_cpol, "R2 idle after transfer", sck_o, cur_cpol);
        end

        // R11 flag clear sequence, observed on irq_o
        bus_write(2'd0, 8'h00);
        bus_write(2'd0, ctl(1, 1, 1, 0, 0, 0));
        bus_write(2'd2, 8'h5A);
        for (int k = 0; k < 200 && !irq_o; k++) @(negedge clk);
        bus_read(2'd2, rd);
        chk(irq_o, "R11 data access alone keeps done", irq_o, 1);
        bus_read(2'd1, rd);
        bus_read(2'd2, rd);
        @(negedge clk);
        chk(!irq_o, "R11 status then data clears done", irq_o, 0);

        // R4 static configuration while enabled
        bus_write(2'd0, ctl(1, 1, 1, 1, 1, 3));
        repeat (3) @(negedge clk);
        bus_read(2'd0, rd);
        chk(rd[3:0] == 4'h0 && sck_o == 1'b0, "R4 cfg write ignored", rd, 8'h70);

        // R6 select ignored in master
        bus_write(2'd3, 8'h01);
        ss_n_i = 1'b0;
        repeat (6) @(negedge clk);
        bus_read(2'd1, rd);
        chk(sck_oe && !rd[6], "R6 no fault with ignore", {sck_oe, rd[6]}, 2'b10);

        // R5 mode fault
        bus_write(2'd3, 8'h00);
        repeat (6) @(negedge clk);
        bus_read(2'd1, rd);
        chk(rd[6], "R5 fault flag", rd, 8'h60);
        chk(!sck_oe && !mosi_oe && irq_o, "R5 drivers released irq set",
            {sck_oe, mosi_oe, irq_o}, 3'b001);
        bus_read(2'd0, rd);
        chk(!rd[4], "R5 master cleared", rd[4], 0);
        ss_n_i = 1'b1;
        bus_write(2'd0, 8'h00);

        // R12 / R7 slave selected
        bus_write(2'd0, ctl(0, 1, 0, 0, 0, 0));
        bus_write(2'd2, 8'hA5);
        ss_n_i = 1'b0;
        repeat (6) @(negedge clk);
        chk(miso_oe && miso_o == 1'b1, "R12 MSB before first edge", {miso_oe, miso_o}, 2'b11);
        slave_xfer(8'h3C, got);
        chk(got == 8'hA5, "R12 slave sends MSB first", got, 8'hA5);
        bus_read(2'd1, rd);
        chk(rd[7], "R7 slave done while selected", rd, 8'hA0);
        bus_read(2'd2, rd);
        chk(rd == 8'h3C, "R7 slave received byte", rd, 8'h3C);

        // R9 output disabled
        bus_write(2'd3, 8'h02);
        repeat (4) @(negedge clk);
        chk(!miso_oe, "R9 miso released", miso_oe, 0);
        bus_write(2'd3, 8'h00);

        // R7 deselected slave ignores clocks
        ss_n_i = 1'b1;
        repeat (4) @(negedge clk);
        chk(!miso_oe, "R7 miso off when deselected", miso_oe, 0);
        slave_xfer(8'hF0, got);
        bus_read(2'd1, rd);
        chk(!rd[7], "R7 no done when deselected", rd[7], 0);

        // R8 slave with select ignored
        bus_write(2'd3, 8'h01);
        bus_write(2'd2, 8'h96);
        repeat (6) @(negedge clk);
        slave_xfer(8'h69, got);
        chk(got == 8'h96, "R8 slave sends with ss high", got, 8'h96);
        bus_read(2'd1, rd);
        bus_read(2'd2, rd);
        chk(rd == 8'h69, "R8 slave receives with ss high", rd, 8'h69);

        if (!ended) begin
            ended = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule